// File: doc/BRIEF.md
# Interrupt Entry Sequencer for an 8-bit CPU

This block carries out the entry part of servicing a reset, a non-maskable interrupt or a maskable interrupt for an 8-bit processor whose stack sits in memory page 1. The surrounding core keeps running its instructions. At each point where interrupts may be sampled, it raises `checkNow` for one cycle and presents its current program counter, stack pointer and status flags. If a request is pending, the sequencer takes control of a byte-wide memory port. It pushes the return state where required, raises the interrupt-disable flag and reads the 16-bit little-endian vector. It then hands back the new program counter, the new stack pointer and the new I flag, together with a one-cycle `done` strobe.

Requests are held in the sequencer between sampling points. Reset is a held request. The non-maskable input is edge-sensitive: a rising edge is remembered until it is serviced. The two maskable sources are levels, and they count only while I is clear. Only one request is taken per sampling point, in the fixed order reset, then non-maskable, then maskable. The memory port makes one access per clock, so an NMI or IRQ entry uses five port cycles: three stack writes followed by two vector reads. A reset entry uses only the two vector reads.

Top module: `irq_entry_seq`

## Requirements
- R1: After `rstN` is released, the block is idle: `busy`=0, `done`=0, `memWrite`=0, `memRead`=0, `newSp`=8'hFF, `newIFlag`=1, `newPc`=16'h0000, `takenKind`=0 and `entryCost`=0.
- R2: When idle with `checkNow`=1, exactly one pending request is taken, chosen in the order reset, non-maskable, maskable. `takenKind` shows the taken request while `done` is 1, coded 1 for reset, 2 for non-maskable and 3 for maskable. It is 0 at all other times.
- R3: A maskable entry starts only if `irqA` or `irqB` is 1 and the I flag (`curFlags[2]`) is 0 in the `checkNow` cycle. Otherwise no memory access and no `busy` follow.
- R4: A 0-to-1 transition of `nmiLine` marks a non-maskable request as pending. Holding the line at 1 does not mark it again. Servicing the request clears the mark, unless a new transition arrives in the same cycle, in which case the mark remains.
- R5: For a non-maskable or maskable entry, the three cycles after acceptance each write one byte to address 16'h0100 | SP, and SP decreases by one after each write, wrapping from 8'h00 to 8'hFF. The bytes are written in this order: PC[15:8], PC[7:0], status.
- R6: The status byte is {N,V,1,0,D,I,Z,C} from bit 7 down to bit 0. It is built from `curFlags` = {N,V,D,I,Z,C} (bits 5..0) captured at acceptance.
- R7: After the pushes (or right after acceptance for reset), two read cycles address the vector low byte and then the high byte. The vector bases are 16'hFFFA for non-maskable, 16'hFFFC for reset and 16'hFFFE for maskable. `newPc` = {high byte, low byte} in the last read cycle and is held afterwards.
- R8: A reset entry performs no write, sets `newSp` to 8'hFF and `newIFlag` to 1 from the first cycle after acceptance, and takes exactly two port cycles.
- R9: When `done` is 1, `newIFlag` is 1. `entryCost` is 7 for a non-maskable or maskable entry and 0 for a reset entry.
- R10: While `busy`, `checkNow` has no effect on the running sequence. Requests that arrive meanwhile are remembered and are taken at the next `checkNow` after the sequence ends.
- R11: `busy` is 1 from the cycle after acceptance through the last read cycle. `done` is 1 for exactly that last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| checkNow | input | 1 | Interrupt sampling point from the core |
| resetReq | input | 1 | Reset request, remembered until serviced |
| nmiLine | input | 1 | Non-maskable request line, edge-sensitive |
| irqA | input | 1 | Maskable source A, level |
| irqB | input | 1 | Maskable source B, level |
| curPc | input | 16 | Core program counter at the sampling point |
| curSp | input | 8 | Core stack pointer at the sampling point |
| curFlags | input | 6 | Core flags {N,V,D,I,Z,C} |
| memAddr | output | 16 | Memory port address |
| memWrite | output | 1 | Memory write strobe |
| memWdata | output | 8 | Memory write data |
| memRead | output | 1 | Memory read strobe |
| memRdata | input | 8 | Memory read data, valid in the same cycle |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Last cycle of an entry |
| takenKind | output | 2 | Kind of entry shown while done is 1 |
| entryCost | output | 4 | Cycle cost reported with done |
| newPc | output | 16 | Loaded vector |
| newSp | output | 8 | Stack pointer after entry |
| newIFlag | output | 1 | Interrupt-disable flag after entry |

## Verification
The collision of interest happens when a non-maskable request is accepted in the same cycle that a new rising edge arrives on its line. The latch is cleared by the service and set again by the edge in the same cycle. The bench provokes this by raising `nmiLine` in exactly the cycle where `checkNow` picks up an earlier pending edge. The collision is judged correct only if a second non-maskable entry follows at the next sampling point with no further edge. A second overlap is also covered: a reset request and a `checkNow` pulse are injected while a push is in progress. The running sequence must keep its addresses and data, and the reset entry must follow only at the next sampling point.

// File: rtl/irqent_pkg.sv
package irqent_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int FLAG_W = 6;
  localparam int FLAG_I = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_ST, ST_VEC_LO, ST_VEC_HI
  } seqState_t;

  typedef enum logic [1:0] {
    K_NONE = 2'd0, K_RESET = 2'd1, K_NMI = 2'd2, K_IRQ = 2'd3
  } entryKind_t;

  typedef struct packed {
    logic       capture;
    logic       isReset;
    logic       pushHi;
    logic       pushLo;
    logic       pushSt;
    logic       vecLo;
    logic       vecHi;
    logic [1:0] vecSel;
  } seqStrobe_t;
endpackage

// File: rtl/irqent_ctrl.sv
module irqent_ctrl
  import irqent_pkg::*;
#(
  parameter int COST_W     = 4,
  parameter int ENTRY_COST = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              checkNow,
  input  logic              resetReq,
  input  logic              nmiLine,
  input  logic              irqA,
  input  logic              irqB,
  input  logic              iFlagNow,
  output seqStrobe_t        strb,
  output logic              busy,
  output logic              done,
  output entryKind_t        takenKind,
  output logic [COST_W-1:0] entryCost
);

  seqState_t  state, stateNxt;
  entryKind_t kindR, pick;
  logic nmiPrev, nmiPend, rstPend;
  logic nmiEdge, irqOk, accept;

  always_comb begin
    nmiEdge = nmiLine & ~nmiPrev;
    irqOk   = (irqA | irqB) & ~iFlagNow;
    if (rstPend)      pick = K_RESET;
    else if (nmiPend) pick = K_NMI;
    else if (irqOk)   pick = K_IRQ;
    else              pick = K_NONE;
    accept = (state == ST_IDLE) && checkNow && (pick != K_NONE);
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:    if (accept) stateNxt = (pick == K_RESET) ? ST_VEC_LO : ST_PUSH_HI;
      ST_PUSH_HI: stateNxt = ST_PUSH_LO;
      ST_PUSH_LO: stateNxt = ST_PUSH_ST;
      ST_PUSH_ST: stateNxt = ST_VEC_LO;
      ST_VEC_LO:  stateNxt = ST_VEC_HI;
      ST_VEC_HI:  stateNxt = ST_IDLE;
      default:    stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.capture = accept;
    strb.isReset = (pick == K_RESET);
    strb.pushHi  = (state == ST_PUSH_HI);
    strb.pushLo  = (state == ST_PUSH_LO);
    strb.pushSt  = (state == ST_PUSH_ST);
    strb.vecLo   = (state == ST_VEC_LO);
    strb.vecHi   = (state == ST_VEC_HI);
    strb.vecSel  = (state == ST_IDLE) ? pick : kindR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kindR   <= K_NONE;
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
      rstPend <= 1'b0;
    end else begin
      state   <= stateNxt;
      nmiPrev <= nmiLine;
      if (accept) kindR <= pick;
      nmiPend <= nmiEdge | (nmiPend & ~(accept && pick == K_NMI));
      rstPend <= resetReq | (rstPend & ~(accept && pick == K_RESET));
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_VEC_HI);
  assign takenKind = done ? kindR : K_NONE;
  assign entryCost = (done && kindR != K_RESET) ? COST_W'(ENTRY_COST) : '0;

  // R4
  nmi_edge_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiLine) |=> nmiPend);

  // R2
  reset_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && checkNow && rstPend) |=> (state == ST_VEC_LO && kindR == K_RESET));

  // R10
  busy_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  // R8
  reset_no_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && kindR == K_RESET) |-> !(strb.pushHi || strb.pushLo || strb.pushSt));

endmodule

// File: rtl/irqent_dp.sv
module irqent_dp
  import irqent_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [BYTE_W-1:0] curSp,
  input  logic [FLAG_W-1:0] curFlags,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memRead,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] newPc,
  output logic [BYTE_W-1:0] newSp,
  output logic              newIFlag
);

  logic [ADDR_W-1:0] pcR, vecR, vecPick;
  logic [BYTE_W-1:0] spR, stR, loR, statusNow;
  logic              iR, anyPush;

  always_comb begin
    // {N,V,1,B=0,D,I,Z,C}
    statusNow = {curFlags[5], curFlags[4], 1'b1, 1'b0,
                 curFlags[3], curFlags[2], curFlags[1], curFlags[0]};
    unique case (strb.vecSel)
      K_NMI:   vecPick = VEC_NMI;
      K_RESET: vecPick = VEC_RST;
      default: vecPick = VEC_IRQ;
    endcase
    anyPush = strb.pushHi | strb.pushLo | strb.pushSt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcR  <= '0;
      vecR <= '0;
      spR  <= '1;
      stR  <= '0;
      loR  <= '0;
      iR   <= 1'b1;
    end else begin
      if (strb.capture) begin
        pcR  <= curPc;
        spR  <= strb.isReset ? '1 : curSp;
        stR  <= statusNow;
        iR   <= strb.isReset ? 1'b1 : curFlags[FLAG_I];
        vecR <= vecPick;
      end
      if (anyPush)     spR <= spR - 1'b1;
      if (strb.pushSt) iR  <= 1'b1;
      if (strb.vecLo)  loR <= memRdata;
      if (strb.vecHi)  pcR <= {memRdata, loR};
    end
  end

  always_comb begin
    memWrite = anyPush;
    memRead  = strb.vecLo | strb.vecHi;
    memAddr  = '0;
    memWdata = '0;
    if (anyPush)         memAddr = {STACK_PAGE, spR};
    else if (strb.vecLo) memAddr = vecR;
    else if (strb.vecHi) memAddr = vecR + 1'b1;
    if (strb.pushHi)      memWdata = pcR[ADDR_W-1:BYTE_W];
    else if (strb.pushLo) memWdata = pcR[BYTE_W-1:0];
    else if (strb.pushSt) memWdata = stR;
  end

  assign newPc    = strb.vecHi ? {memRdata, loR} : pcR;
  assign newSp    = spR;
  assign newIFlag = iR;

  // R5
  sp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |=> newSp == $past(newSp) - 8'd1);

  // R7
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRead, memWrite}));

  // R9
  iflag_before_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRead |-> newIFlag);

  // R7
  vec_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.vecLo |=> memRead && memAddr == $past(memAddr) + 16'd1);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irqent_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE,
  parameter int                COST_W     = 4,
  parameter int                ENTRY_COST = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              checkNow,
  input  logic              resetReq,
  input  logic              nmiLine,
  input  logic              irqA,
  input  logic              irqB,
  input  logic [15:0]       curPc,
  input  logic [7:0]        curSp,
  input  logic [5:0]        curFlags,
  output logic [15:0]       memAddr,
  output logic              memWrite,
  output logic [7:0]        memWdata,
  output logic              memRead,
  input  logic [7:0]        memRdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        takenKind,
  output logic [COST_W-1:0] entryCost,
  output logic [15:0]       newPc,
  output logic [7:0]        newSp,
  output logic              newIFlag
);

  seqStrobe_t strb;
  entryKind_t kindOut;

  irqent_ctrl #(.COST_W(COST_W), .ENTRY_COST(ENTRY_COST)) uCtrl (
    .clk(clk), .rstN(rstN), .checkNow(checkNow), .resetReq(resetReq),
    .nmiLine(nmiLine), .irqA(irqA), .irqB(irqB), .iFlagNow(curFlags[FLAG_I]),
    .strb(strb), .busy(busy), .done(done), .takenKind(kindOut), .entryCost(entryCost)
  );

  irqent_dp #(.STACK_PAGE(STACK_PAGE), .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST),
              .VEC_IRQ(VEC_IRQ)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .curPc(curPc), .curSp(curSp),
    .curFlags(curFlags), .memAddr(memAddr), .memWrite(memWrite), .memWdata(memWdata),
    .memRead(memRead), .memRdata(memRdata), .newPc(newPc), .newSp(newSp),
    .newIFlag(newIFlag)
  );

  assign takenKind = kindOut;

  // R11
  done_in_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> memRead && busy);

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  logic clk = 1'b0, rstN = 1'b0;
  logic checkNow = 0, resetReq = 0, nmiLine = 0, irqA = 0, irqB = 0;
  logic [15:0] curPc = 0;
  logic [7:0]  curSp = 0;
  logic [5:0]  curFlags = 0;
  logic [15:0] memAddr, newPc;
  logic memWrite, memRead, busy, done, newIFlag;
  logic [7:0] memWdata, memRdata, newSp;
  logic [1:0] takenKind;
  logic [3:0] entryCost;
  logic [7:0] salt = 8'h00;
  int nChecks = 0, nFails = 0;
  bit rstPM = 0, nmiPM = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] memFn(logic [15:0] a, logic [7:0] s);
    return a[7:0] ^ a[15:8] ^ s ^ 8'h3C;
  endfunction
  assign memRdata = memFn(memAddr, salt);

  irq_entry_seq dut (.*);

  function automatic logic [7:0] stByte(logic [5:0] f);
    return {f[5], f[4], 1'b1, 1'b0, f[3], f[2], f[1], f[0]};
  endfunction

  function automatic logic [15:0] vecBase(int k);
    return (k == 1) ? 16'hFFFC : (k == 2) ? 16'hFFFA : 16'hFFFE;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // called right after checkNow was raised at a negedge
  task automatic runEntry(input int kind, input logic [15:0] pc, input logic [7:0] sp,
                          input logic [5:0] fl, input bit intrude);
    logic [7:0] s, b;
    logic [15:0] base;
    s = sp;
    base = vecBase(kind);
    @(negedge clk);
    checkNow = 0;
    if (kind == 0) begin
      chk("R3 idle busy", busy, 0);
      chk("R3 idle write", memWrite, 0);
      chk("R10 idle read", memRead, 0);
      return;
    end
    if (kind != 1) begin
      for (int k = 0; k < 3; k++) begin
        b = (k == 0) ? pc[15:8] : (k == 1) ? pc[7:0] : stByte(fl);
        chk("R5 write", memWrite, 1);
        chk("R5 addr", memAddr, {8'h01, s});
        chk(k == 2 ? "R6 status" : "R5 data", memWdata, b);
        chk("R11 busy", busy, 1);
        if (intrude && k == 0) begin checkNow = 1; resetReq = 1; end
        else if (intrude && k == 1) begin checkNow = 0; resetReq = 0; rstPM = 1; end
        s = s - 8'd1;
        @(negedge clk);
      end
    end else begin
      chk("R8 no write", memWrite, 0);
      chk("R8 sp", newSp, 8'hFF);
      chk("R8 iflag", newIFlag, 1);
      s = 8'hFF;
    end
    chk("R7 read lo", memRead, 1);
    chk("R7 addr lo", memAddr, base);
    chk("R11 not done", done, 0);
    @(negedge clk);
    chk("R11 done", done, 1);
    chk("R7 addr hi", memAddr, base + 16'd1);
    chk("R7 newPc", newPc, {memFn(base + 16'd1, salt), memFn(base, salt)});
    chk("R2 kind", takenKind, kind);
    chk("R9 cost", entryCost, (kind == 1) ? 0 : 7);
    chk("R5 sp", newSp, s);
    chk("R9 iflag", newIFlag, 1);
    @(negedge clk);
    chk("R11 done drop", done, 0);
    chk("R11 busy drop", busy, 0);
    chk("R7 pc held", newPc, {memFn(base + 16'd1, salt), memFn(base, salt)});
    chk("R2 kind idle", takenKind, 0);
  endtask

  // three idle cycles: set inputs, optional NMI edge, then sampling point
  task automatic entry(input bit r, input bit nEdge, input bit a, input bit b,
                       input logic [15:0] pc, input logic [7:0] sp, input logic [5:0] fl,
                       input bit intrude);
    int k;
    @(negedge clk);
    checkNow = 0; resetReq = r; irqA = a; irqB = b;
    curPc = pc; curSp = sp; curFlags = fl; salt = 8'($urandom);
    if (nEdge) nmiLine = 0;
    @(negedge clk);
    resetReq = 0;
    if (nEdge) nmiLine = 1;
    @(negedge clk);
    rstPM = rstPM | r;
    nmiPM = nmiPM | nEdge;
    checkNow = 1;
    if (rstPM) begin k = 1; rstPM = 0; end
    else if (nmiPM) begin k = 2; nmiPM = 0; end
    else if ((a | b) && !fl[2]) k = 3;
    else k = 0;
    runEntry(k, pc, sp, fl, intrude && k >= 2);
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 write", memWrite, 0);
    chk("R1 read", memRead, 0);
    chk("R1 sp", newSp, 8'hFF);
    chk("R1 iflag", newIFlag, 1);
    chk("R1 pc", newPc, 0);
    chk("R1 kind", takenKind, 0);
    chk("R1 cost", entryCost, 0);

    // R3/R5 maskable entry with stack wrap (SP=01 -> FE)
    entry(0, 0, 1, 0, 16'h1234, 8'h01, 6'b101001, 0);
    // R3 masked by I
    entry(0, 0, 0, 1, 16'h4321, 8'h80, 6'b000100, 0);
    // R4 NMI edge, then held-high line gives no new request
    entry(0, 1, 0, 0, 16'hABCD, 8'hF0, 6'b111111, 0);
    entry(0, 0, 0, 0, 16'h0000, 8'h10, 6'b000000, 0);
    // R2 all at once: reset, then NMI, then IRQ
    entry(1, 1, 1, 1, 16'h5555, 8'h40, 6'b010010, 0);
    entry(0, 0, 1, 1, 16'h6666, 8'h41, 6'b010010, 0);
    entry(0, 0, 1, 1, 16'h7777, 8'h42, 6'b010010, 0);
    // R10 intrusion during busy, then the remembered reset
    entry(0, 0, 0, 1, 16'h9A9A, 8'h20, 6'b000000, 1);
    entry(0, 0, 0, 0, 16'h0101, 8'h30, 6'b000100, 0);

    // R4 edge in the accept cycle keeps the request pending
    @(negedge clk); nmiLine = 0; irqA = 0; irqB = 0; curPc = 16'hC0DE; curSp = 8'h77;
    @(negedge clk); nmiLine = 1;
    @(negedge clk); nmiLine = 0;
    @(negedge clk); nmiLine = 1; checkNow = 1;
    runEntry(2, 16'hC0DE, 8'h77, curFlags, 0);
    @(negedge clk); checkNow = 1;
    runEntry(2, 16'hC0DE, 8'h77, curFlags, 0);
    nmiPM = 0;

    for (int it = 0; it < 300; it++) begin
      entry(($urandom % 6) == 0, ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
            16'($urandom), 8'($urandom), 6'($urandom), ($urandom % 8) == 0);
    end
    finishRun();
  end
endmodule